// File: doc/BRIEF.md
# Excluding Random Tag Generator

This block picks a 4-bit allocation tag for a pointer and writes it into the tag field of a 64-bit address (bits 59:56). It keeps a small state word: a 16-bit pseudo-random seed and the last tag it chose. In random mode, every request advances the seed through four shift-register steps, and the four feedback bits form an offset. Starting from the stored tag, a search then walks forward through the tag space modulo 16 by that offset. It counts only tags that are not excluded. The chosen tag and the advanced seed replace the state.

In the add-tag mode the random source is not used. The start tag is read from the incoming pointer's tag field. A caller-supplied tag offset goes through the same excluding search, and a byte offset is added to the address before the tag is inserted. Requests use a valid/ready handshake. The search tests one candidate tag per cycle, and a one-cycle `done` pulse marks the result. The state word can be loaded while the block is idle.

Top module: `excl_tag_gen`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0 and `state_out` equals zero.
- R2: In random mode one seed step forms feedback = s[5]^s[3]^s[2]^s[0] and yields {feedback, s[15:1]}. Four steps run per request, and the feedback of step i (i = 0..3) is bit i of the offset.
- R3: With offset 0, the result is the start tag if that tag is not excluded. Otherwise it is the first non-excluded tag found by counting upward modulo 16.
- R4: With offset k > 0, the search increments the tag modulo 16 and counts only non-excluded tags, and the k-th such tag is the result. The start tag itself is never counted.
- R5: If the effective exclusion mask is 0xFFFF, the result tag is 0 and `done` rises in the cycle after acceptance.
- R6: In random mode the effective exclusion mask is `req_excl | cfg_excl`. Bit t set excludes tag t.
- R7: When a random-mode request completes, `state_out` holds the advanced seed in bits 23:8, bits 7:4 are 0, and bits 3:0 hold the chosen tag.
- R8: In add-tag mode the start tag is `req_addr[59:56]`, the offset is `req_tag_ofs`, and the mask is `cfg_excl` alone. The result address is based on `req_addr + req_byte_ofs` (modulo 2^64), and `state_out` does not change.
- R9: `res_addr` is the base address with bits 59:56 replaced by `res_tag`. Every other bit is kept.
- R10: `req_ready` is low while a search runs, and requests presented then are ignored. `done` is a single-cycle pulse.
- R11: With `state_ld` high while idle, `state_out` becomes `state_ld_val` with bits 7:4 cleared, and `req_ready` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| state_ld | input | 1 | Load the state word |
| state_ld_val | input | 24 | Value to load: seed in 23:8, tag in 3:0 |
| cfg_excl | input | 16 | Configured exclusion mask |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_mode | input | 1 | 0 = random tag, 1 = add-tag |
| req_addr | input | 64 | Input pointer |
| req_excl | input | 16 | Per-request exclusion mask (random mode) |
| req_tag_ofs | input | 4 | Tag offset (add-tag mode) |
| req_byte_ofs | input | 64 | Byte offset added to the address (add-tag mode) |
| done | output | 1 | Result valid pulse |
| res_tag | output | 4 | Chosen tag |
| res_addr | output | 64 | Address with chosen tag inserted |
| state_out | output | 24 | Current state word |

## Verification
A zero seed forces offset 0. Loading a zero seed with every start tag, under empty, single-bit, near-full and alternating masks, isolates the zero-offset acceptance rule from the stepping rule. A long random-mode run from a nonzero seed checks the shift-register sequence and the writeback of tag and seed across many chained requests, and mixes the two mask sources so that an error in how they are combined changes the tag. The add-tag mode is swept over every start tag and every offset under several masks, with carries and negative byte offsets. This separates wrap-around, skipping and the all-excluded result. Requests presented during a search show whether the handshake ignores them.

// File: rtl/tagg_pkg.sv
package tagg_pkg;
    localparam int TAG_W    = 4;
    localparam int NTAG     = 1 << TAG_W;
    localparam int SEED_W   = 16;
    localparam int SEED_LSB = 8;
    localparam int STATE_W  = SEED_LSB + SEED_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [NTAG-1:0]   tmask_t;
    typedef logic [SEED_W-1:0] seed_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_SEARCH = 1'b1} st_e;
    typedef enum logic {MODE_RAND = 1'b0, MODE_ADD = 1'b1} mode_e;
endpackage

// File: rtl/tagg_seed_adv.sv
module tagg_seed_adv
    import tagg_pkg::*;
#(
    parameter int STEPS = TAG_W
) (
    input  seed_t             seed_i,
    output seed_t             seed_o,
    output logic [STEPS-1:0]  ofs_o
);
    seed_t chain [STEPS+1];

    assign chain[0] = seed_i;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        logic fb;
        assign fb           = chain[g][5] ^ chain[g][3] ^ chain[g][2] ^ chain[g][0];
        assign chain[g+1]   = {fb, chain[g][SEED_W-1:1]};
        assign ofs_o[g]     = fb;
    end

    assign seed_o = chain[STEPS];
endmodule

// File: rtl/tagg_tag_insert.sv
module tagg_tag_insert
    import tagg_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int TAG_LSB = 56
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  tag_t              tag_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] FIELD =
        {{(ADDR_W-TAG_W){1'b0}}, {TAG_W{1'b1}}} << TAG_LSB;

    assign addr_o = (addr_i & ~FIELD) | ({{(ADDR_W-TAG_W){1'b0}}, tag_i} << TAG_LSB);
endmodule

// File: rtl/excl_tag_gen.sv
module excl_tag_gen
    import tagg_pkg::*;
#(
    parameter int                   ADDR_W    = 64,
    parameter int                   TAG_LSB   = 56,
    parameter logic [STATE_W-1:0]   RST_STATE = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 state_ld,
    input  logic [STATE_W-1:0]   state_ld_val,
    input  logic [NTAG-1:0]      cfg_excl,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_mode,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [NTAG-1:0]      req_excl,
    input  logic [TAG_W-1:0]     req_tag_ofs,
    input  logic [ADDR_W-1:0]    req_byte_ofs,
    output logic                 done,
    output logic [TAG_W-1:0]     res_tag,
    output logic [ADDR_W-1:0]    res_addr,
    output logic [STATE_W-1:0]   state_out
);
    localparam int PAD_W = SEED_LSB - TAG_W;

    typedef struct packed {
        st_e                 st;
        mode_e               mode;
        tag_t                cur;
        tag_t                rem;
        tmask_t              mask;
        seed_t               seed_nxt;
        logic [ADDR_W-1:0]   addr;
        logic                done;
        tag_t                res_tag;
        logic [STATE_W-1:0]  state;
    } regs_t;

    regs_t q, d;

    seed_t  cur_seed;
    tag_t   cur_start;
    seed_t  adv_seed;
    tag_t   rand_ofs;
    mode_e  in_mode;
    tmask_t eff_mask_c;
    tag_t   start_c;
    tag_t   ofs_c;
    logic   accept;

    assign cur_seed  = q.state[STATE_W-1:SEED_LSB];
    assign cur_start = q.state[TAG_W-1:0];
    assign in_mode   = mode_e'(req_mode);

    tagg_seed_adv #(.STEPS(TAG_W)) u_seed (
        .seed_i (cur_seed),
        .seed_o (adv_seed),
        .ofs_o  (rand_ofs)
    );

    tagg_tag_insert #(.ADDR_W(ADDR_W), .TAG_LSB(TAG_LSB)) u_ins (
        .addr_i (q.addr),
        .tag_i  (q.res_tag),
        .addr_o (res_addr)
    );

    assign req_ready  = (q.st == ST_IDLE) && !state_ld;
    assign accept     = req_valid && req_ready;
    assign eff_mask_c = (in_mode == MODE_ADD) ? cfg_excl : (cfg_excl | req_excl);
    assign start_c    = (in_mode == MODE_ADD) ? req_addr[TAG_LSB +: TAG_W] : cur_start;
    assign ofs_c      = (in_mode == MODE_ADD) ? req_tag_ofs : rand_ofs;

    always_comb begin
        tag_t nxt;
        logic fin;
        tag_t fin_tag;

        d       = q;
        d.done  = 1'b0;
        nxt     = q.cur + tag_t'(1);
        fin     = 1'b0;
        fin_tag = '0;

        if (q.st == ST_IDLE) begin
            if (state_ld) begin
                d.state = {state_ld_val[STATE_W-1:SEED_LSB], {PAD_W{1'b0}},
                           state_ld_val[TAG_W-1:0]};
            end else if (accept) begin
                d.mode     = in_mode;
                d.mask     = eff_mask_c;
                d.cur      = start_c;
                d.rem      = ofs_c;
                d.seed_nxt = adv_seed;
                d.addr     = (in_mode == MODE_ADD) ? (req_addr + req_byte_ofs) : req_addr;
                if (&eff_mask_c) begin
                    fin     = 1'b1;
                    fin_tag = '0;
                end else begin
                    d.st = ST_SEARCH;
                end
            end
        end else begin
            if (q.rem == '0) begin
                if (q.mask[q.cur]) begin
                    d.cur = nxt;
                end else begin
                    fin     = 1'b1;
                    fin_tag = q.cur;
                end
            end else begin
                d.cur = nxt;
                if (!q.mask[nxt]) begin
                    if (q.rem == tag_t'(1)) begin
                        fin     = 1'b1;
                        fin_tag = nxt;
                    end else begin
                        d.rem = q.rem - tag_t'(1);
                    end
                end
            end
        end

        if (fin) begin
            d.st      = ST_IDLE;
            d.done    = 1'b1;
            d.res_tag = fin_tag;
            if (d.mode == MODE_RAND) begin
                d.state = {d.seed_nxt, {PAD_W{1'b0}}, fin_tag};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.mode     <= MODE_RAND;
            q.state    <= RST_STATE;
        end else begin
            q <= d;
        end
    end

    assign done      = q.done;
    assign res_tag   = q.res_tag;
    assign state_out = q.state;

    // R5: a fully excluded mask yields tag 0 one cycle after acceptance
    a_r5_all_excl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (&eff_mask_c)) |=> (done && res_tag == '0));

    // R10: a search in progress blocks further requests
    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(&eff_mask_c)) |=> !req_ready);

    // R3/R4: a produced tag is never one of the excluded tags
    a_r3_tag_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(&q.mask)) |-> !q.mask[res_tag]);

    // R7: random-mode completion writes the chosen tag back to the state
    a_r7_state_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.mode == MODE_RAND) |-> (state_out[TAG_W-1:0] == res_tag));

    // R8: add-tag searches leave the state word untouched
    a_r8_add_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SEARCH && q.mode == MODE_ADD) |=> $stable(state_out));
endmodule

// File: tb/excl_tag_gen_tb.sv
module excl_tag_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        state_ld;
    logic [23:0] state_ld_val;
    logic [15:0] cfg_excl;
    logic        req_valid;
    logic        req_ready;
    logic        req_mode;
    logic [63:0] req_addr;
    logic [15:0] req_excl;
    logic [3:0]  req_tag_ofs;
    logic [63:0] req_byte_ofs;
    logic        done;
    logic [3:0]  res_tag;
    logic [63:0] res_addr;
    logic [23:0] state_out;

    int errors = 0;
    int checks = 0;
    logic [23:0] m_state;

    always #2 clk = ~clk;

    excl_tag_gen dut_i (
        .clk(clk), .rst_n(rst_n), .state_ld(state_ld), .state_ld_val(state_ld_val),
        .cfg_excl(cfg_excl), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_addr(req_addr), .req_excl(req_excl),
        .req_tag_ofs(req_tag_ofs), .req_byte_ofs(req_byte_ofs), .done(done),
        .res_tag(res_tag), .res_addr(res_addr), .state_out(state_out)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [19:0] seed_model(input logic [15:0] s_in);
        logic [15:0] s;
        logic [3:0]  o;
        logic        fb;
        s = s_in;
        o = '0;
        for (int i = 0; i < 4; i++) begin
            fb   = s[5] ^ s[3] ^ s[2] ^ s[0];
            s    = {fb, s[15:1]};
            o[i] = fb;
        end
        return {s, o};
    endfunction

    function automatic logic [3:0] choose(input logic [3:0] start, input logic [3:0] ofs,
                                          input logic [15:0] mask);
        logic [3:0] t;
        if (mask == 16'hFFFF) return 4'h0;
        t = start;
        if (ofs == 0) begin
            while (mask[t]) t = t + 4'h1;
        end else begin
            for (int k = 0; k < ofs; k++) begin
                t = t + 4'h1;
                while (mask[t]) t = t + 4'h1;
            end
        end
        return t;
    endfunction

    task automatic load_state(input logic [23:0] v);
        @(negedge clk);
        state_ld = 1'b1;
        state_ld_val = v;
        #0;
        chk("R11 ready low during load", {63'b0, req_ready}, 64'd0);
        @(negedge clk);
        state_ld = 1'b0;
        m_state = {v[23:8], 4'h0, v[3:0]};
        chk("R11 load", {40'b0, state_out}, {40'b0, m_state});
    endtask

    task automatic run_req(input logic mode, input logic [63:0] addr, input logic [15:0] rexcl,
                           input logic [3:0] tofs, input logic [63:0] bofs, input bit poke,
                           input string rq);
        logic [15:0] mask;
        logic [3:0]  start, ofs, et;
        logic [19:0] sm;
        logic [63:0] base, ea;
        int n;
        sm = seed_model(m_state[23:8]);
        if (mode) begin
            mask = cfg_excl; start = addr[59:56]; ofs = tofs; base = addr + bofs;
        end else begin
            mask = cfg_excl | rexcl; start = m_state[3:0]; ofs = sm[3:0]; base = addr;
        end
        et = choose(start, ofs, mask);
        ea = (base & ~(64'hF << 56)) | ({60'b0, et} << 56);
        if (!mode) m_state = {sm[19:4], 4'h0, et};

        @(negedge clk);
        chk("R10 ready before request", {63'b0, req_ready}, 64'd1);
        req_valid = 1'b1; req_mode = mode; req_addr = addr; req_excl = rexcl;
        req_tag_ofs = tofs; req_byte_ofs = bofs;
        @(negedge clk);
        req_valid = 1'b0;
        if (mask == 16'hFFFF) begin
            chk({rq, " R5 done next cycle"}, {63'b0, done}, 64'd1);
        end else begin
            chk({rq, " R10 ready low while busy"}, {63'b0, req_ready}, 64'd0);
            if (poke) begin
                req_valid = 1'b1; req_mode = ~mode; req_addr = ~addr; req_excl = 16'h0;
                req_tag_ofs = tofs + 4'h3;
                @(negedge clk);
                req_valid = 1'b0;
            end
        end
        n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk({rq, " R10 done seen"}, {63'b0, done}, 64'd1);
        chk({rq, " tag R3/R4"}, {60'b0, res_tag}, {60'b0, et});
        chk({rq, " R9 address"}, res_addr, ea);
        chk({rq, " R7/R8 state"}, {40'b0, state_out}, {40'b0, m_state});
        @(negedge clk);
        chk({rq, " R10 done pulse"}, {63'b0, done}, 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] mlist [4];
        rst_n = 1'b0; state_ld = 0; state_ld_val = 0; cfg_excl = 0; req_valid = 0;
        req_mode = 0; req_addr = 0; req_excl = 0; req_tag_ofs = 0; req_byte_ofs = 0;
        m_state = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", {63'b0, req_ready}, 64'd1);
        chk("R1 done", {63'b0, done}, 64'd0);
        chk("R1 state", {40'b0, state_out}, 64'd0);

        // R3: zero seed gives offset 0 for every start tag
        for (int s = 0; s < 16; s++) begin
            mlist[0] = 16'h0000;
            mlist[1] = 16'h1 << s;
            mlist[2] = ~(16'h1 << ((s + 5) % 16));
            mlist[3] = 16'hAAAA;
            for (int m = 0; m < 4; m++) begin
                load_state({16'h0, 4'h0, 4'(s)});
                run_req(1'b0, 64'h0123_4567_89AB_CDEF, mlist[m], 4'h0, 64'h0, 1'b0, "R3 zero ofs");
            end
        end

        // R2/R4/R6/R7: chained random requests from a nonzero seed
        load_state({16'hACE1, 4'hF, 4'h3});
        for (int i = 0; i < 150; i++) begin
            cfg_excl = (i % 3 == 0) ? 16'h0000 : ((i % 3 == 1) ? 16'h0181 : 16'h7E00);
            run_req(1'b0, {8'hA5, 56'(i * 977)}, 16'((i * 16'h2F1B) ^ (i << 3)) & 16'hF3DF,
                    4'h0, 64'h0, (i % 7) == 0, "R2 R4 R6 random");
        end
        cfg_excl = 16'h00FF;
        run_req(1'b0, 64'hFFFF_0000_1234_5678, 16'hFF00, 4'h0, 64'h0, 1'b1, "R6 R5 merged full");
        cfg_excl = 16'h0000;
        run_req(1'b0, 64'h0F00_0000_0000_0001, 16'hFFFF, 4'h0, 64'h0, 1'b0, "R5 random full");
        run_req(1'b0, 64'h0F00_0000_0000_0002, 16'h0000, 4'h0, 64'h0, 1'b0, "R2 after full");

        // R8: add-tag sweep over start tags and offsets
        mlist[0] = 16'h0000; mlist[1] = 16'h8421; mlist[2] = 16'hFFFE;
        for (int m = 0; m < 3; m++) begin
            cfg_excl = mlist[m];
            for (int s = 0; s < 16; s++) begin
                for (int o = 0; o < 16; o++) begin
                    run_req(1'b1, {4'h5, 4'(s), 56'h00FF_FFFF_FFFF_FF00 + 56'(o)}, 16'hFFFF,
                            4'(o), (o % 2 == 1) ? 64'hFFFF_FFFF_FFFF_FFF0 : 64'h0000_0000_0000_0140,
                            (o == 5), "R8 add sweep");
                end
            end
        end
        cfg_excl = 16'hFFFF;
        run_req(1'b1, 64'h7300_0000_0000_0000, 16'h0000, 4'h4, 64'h10, 1'b0, "R8 R5 add full");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule